// File: doc/BRIEF.md
# Data Cache Maintenance Command Unit

This block carries out maintenance operations on the tag and data storage of a two-way set-associative data cache with 64 sets and 64-byte lines. A requester presents a 5-bit operation code and a 32-bit address together with a one-cycle start pulse. The unit invalidates lines, writes dirty lines back to memory, and lets software read or overwrite a tag word or a single 32-bit data word through a 32-bit transfer value. The transfer value comes in on `xfer_in` and goes out on `xfer_out`.

Commands pick their target in one of two ways. Hit-type commands look the address page up in both ways. Index-type commands name the way directly. A writeback sends the line to memory as four 128-bit beats on a valid/ready port. A single-cycle `cmd_done` pulse marks the end of every command. Normal loads and stores, address translation, and commands aimed at other caches are not handled here. Those other-cache commands are accepted and do nothing.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset, every tag word and every data word reads as zero. `xfer_out`, `cmd_done`, `cmd_unsupported`, `cmd_busy` and `wb_valid` are all low.
- R2: The set is `cmd_addr[11:6]` and index-type commands take the way from `cmd_addr[0]`. Code 0x12 overwrites the whole 32-bit tag word with `xfer_in`. Code 0x10 copies the whole tag word to `xfer_out`.
- R3: Code 0x13 writes `xfer_in` into one data word and code 0x11 copies one data word to `xfer_out`. The quadword is selected by `cmd_addr[5:4]` and the word within it by `cmd_addr[3:2]`.
- R4: Hit-type commands (0x1A, 0x18, 0x1C) hit a way when tag bits [31:12] equal `cmd_addr[31:12]` and tag bit 5 (valid) is set. Way 0 wins when both ways match. A miss completes without changing any state and without a writeback.
- R5: Invalidation (0x1A, 0x18, 0x16, 0x14) clears every tag bit except bit 4 (replacement flag) and sets all 16 data words of the line to zero.
- R6: A writeback command (0x18, 0x1C, 0x14) sends beats only when tag bits 6 (dirty) and 5 (valid) are both set. Otherwise it sends none.
- R7: A writeback sends four beats. Beat k carries address {tag[31:12], set, 6'b0} + 16·k and data {word 4k+3, word 4k+2, word 4k+1, word 4k}. `wb_valid`, `wb_addr` and `wb_data` stay unchanged while `wb_ready` is low.
- R8: Code 0x1C clears only the dirty bit after its writeback. The rest of the tag and the data words are kept.
- R9: Code 0x14 takes the writeback page from the stored tag, not from `cmd_addr[31:12]`.
- R10: Codes 0x07 and 0x0C complete one cycle after start with `cmd_unsupported` low and no change of state.
- R11: Any other unlisted code completes one cycle after start with `cmd_unsupported` high and no change of state.
- R12: `cmd_done` is a single-cycle pulse. It comes one cycle after start when no writeback is needed, or one cycle after the last beat is accepted. While a writeback is in progress, `cmd_busy` is high and `cmd_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle command request |
| cmd_op | input | 5 | Operation code |
| cmd_addr | input | 32 | Command address |
| xfer_in | input | 32 | Word written by the tag and data write commands |
| cmd_busy | output | 1 | Writeback in progress |
| cmd_done | output | 1 | Command completion pulse |
| cmd_unsupported | output | 1 | Pulses with `cmd_done` for an unknown code |
| xfer_out | output | 32 | Word returned by the tag and data read commands |
| wb_valid | output | 1 | Writeback beat offered |
| wb_ready | input | 1 | Memory accepts the beat |
| wb_addr | output | 32 | Byte address of the beat |
| wb_data | output | 128 | Beat data |

## Verification
The assertions assume that `cmd_start` is only raised while `cmd_busy` is low, or that a start raised while busy may be dropped. They also assume that `wb_ready` may follow any pattern, including staying low for several cycles. The bench stays within these assumptions. It issues each command only after the previous `cmd_done`, except in one deliberate start during a stalled writeback. It drives `wb_ready` constantly high, alternating, or held low. The bench builds every tag and data value from the set, way and word number, so aliasing between sets, ways or words shows up as a mismatch.

// File: rtl/cmu_pkg.sv
// Shared constants and types for the cache maintenance command unit.
// Assumes a 32-bit tag word whose low bits carry the line state flags.
package cmu_pkg;
    localparam logic [4:0] OP_RD_TAG      = 5'h10;
    localparam logic [4:0] OP_RD_WORD     = 5'h11;
    localparam logic [4:0] OP_WR_TAG      = 5'h12;
    localparam logic [4:0] OP_WR_WORD     = 5'h13;
    localparam logic [4:0] OP_IDX_WB_INV  = 5'h14;
    localparam logic [4:0] OP_IDX_INV     = 5'h16;
    localparam logic [4:0] OP_HIT_WB_INV  = 5'h18;
    localparam logic [4:0] OP_HIT_INV     = 5'h1A;
    localparam logic [4:0] OP_HIT_WB_KEEP = 5'h1C;
    localparam logic [4:0] OP_NOP_A       = 5'h07;
    localparam logic [4:0] OP_NOP_B       = 5'h0C;

    localparam int REPL_BIT  = 4;
    localparam int VALID_BIT = 5;
    localparam int DIRTY_BIT = 6;
    localparam logic [31:0] REPL_MASK  = 32'h1 << REPL_BIT;
    localparam logic [31:0] DIRTY_MASK = 32'h1 << DIRTY_BIT;

    typedef struct packed {
        logic by_hit;    // target way found by page lookup
        logic inval;     // invalidate the target line
        logic wb;        // write back when dirty and valid
        logic keep;      // after writeback, only clear dirty
        logic rd_tag;
        logic rd_word;
        logic wr_tag;
        logic wr_word;
        logic unknown;   // code outside the command set
    } cmd_class_t;
endpackage

// File: rtl/cmu_decode.sv
// Operation code decoder. Maps a 5-bit code to a set of action flags.
// Assumes the code is stable during the cycle in which start is high.
module cmu_decode
    import cmu_pkg::*;
(
    input  logic [4:0]  op,
    output cmd_class_t  cls
);
    // Translate the code into action flags; no-op codes leave all flags low.
    always_comb begin
        cls = '0;
        case (op)
            OP_RD_TAG:      cls.rd_tag  = 1'b1;
            OP_RD_WORD:     cls.rd_word = 1'b1;
            OP_WR_TAG:      cls.wr_tag  = 1'b1;
            OP_WR_WORD:     cls.wr_word = 1'b1;
            OP_IDX_INV:     cls.inval   = 1'b1;
            OP_IDX_WB_INV: begin
                cls.inval = 1'b1;
                cls.wb    = 1'b1;
            end
            OP_HIT_INV: begin
                cls.by_hit = 1'b1;
                cls.inval  = 1'b1;
            end
            OP_HIT_WB_INV: begin
                cls.by_hit = 1'b1;
                cls.inval  = 1'b1;
                cls.wb     = 1'b1;
            end
            OP_HIT_WB_KEEP: begin
                cls.by_hit = 1'b1;
                cls.wb     = 1'b1;
                cls.keep   = 1'b1;
            end
            OP_NOP_A, OP_NOP_B: cls = '0;
            default:        cls.unknown = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmu_tag_store.sv
// Tag storage for two ways, with a page comparator per way.
// Assumes one write per cycle; reads of the addressed set are combinational.
module cmu_tag_store
    import cmu_pkg::*;
#(
    parameter int SET_BITS = 6,
    parameter int PAGE_LSB = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_BITS-1:0]   set_idx,
    input  logic [31-PAGE_LSB:0]  page,
    input  logic                  we,
    input  logic                  we_way,
    input  logic [31:0]           wdata,
    output logic [1:0][31:0]      tag_rd,
    output logic [1:0]            hit
);
    localparam int NUM_SETS = 1 << SET_BITS;

    logic [31:0] tags [2][NUM_SETS];

    // Clear all tags on reset, otherwise apply the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < NUM_SETS; s++)
                    tags[w][s] <= '0;
        end else if (we) begin
            tags[we_way][set_idx] <= wdata;
        end
    end

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign tag_rd[w] = tags[w][set_idx];
        assign hit[w]    = tag_rd[w][VALID_BIT] && (tag_rd[w][31:PAGE_LSB] == page);
    end
endmodule

// File: rtl/cmu_data_store.sv
// Data storage for two ways of 32-bit words, with a word port,
// a whole-line clear and a 128-bit quadword read for writebacks.
// Assumes the word write and the line clear never occur together.
module cmu_data_store #(
    parameter int SET_BITS  = 6,
    parameter int WORD_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_BITS-1:0]   set_idx,
    input  logic                  way,
    input  logic [WORD_BITS-1:0]  word_idx,
    input  logic                  word_we,
    input  logic [31:0]           word_wdata,
    input  logic                  line_clr,
    input  logic [WORD_BITS-3:0]  beat,
    output logic [31:0]           word_rdata,
    output logic [127:0]          quad_rdata
);
    localparam int WORDS = 1 << WORD_BITS;
    localparam int DEPTH = 2 * (1 << SET_BITS) * WORDS;

    logic [31:0] mem [DEPTH];

    // Reset to zero, then either clear the addressed line or write one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (line_clr) begin
            for (int j = 0; j < WORDS; j++)
                mem[{way, set_idx, WORD_BITS'(j)}] <= '0;
        end else if (word_we) begin
            mem[{way, set_idx, word_idx}] <= word_wdata;
        end
    end

    assign word_rdata = mem[{way, set_idx, word_idx}];

    for (genvar k = 0; k < 4; k++) begin : g_quad
        assign quad_rdata[32*k +: 32] = mem[{way, set_idx, beat, 2'(k)}];
    end

    assert_clr_excl_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_clr && word_we));
endmodule

// File: rtl/cache_maint_unit.sv
// Cache maintenance command unit: runs invalidate, writeback and direct
// tag/data access commands on a two-way cache and drives the writeback port.
// Assumes start is only honoured while not busy; a start during a writeback is dropped.
module cache_maint_unit
    import cmu_pkg::*;
#(
    parameter int SET_BITS  = 6,
    parameter int WORD_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [4:0]    cmd_op,
    input  logic [31:0]   cmd_addr,
    input  logic [31:0]   xfer_in,
    output logic          cmd_busy,
    output logic          cmd_done,
    output logic          cmd_unsupported,
    output logic [31:0]   xfer_out,
    output logic          wb_valid,
    input  logic          wb_ready,
    output logic [31:0]   wb_addr,
    output logic [127:0]  wb_data
);
    localparam int OFF_BITS  = WORD_BITS + 2;
    localparam int PAGE_LSB  = OFF_BITS + SET_BITS;
    localparam int BEAT_BITS = WORD_BITS - 2;
    localparam int NUM_BEATS = 1 << BEAT_BITS;

    typedef enum logic {ST_IDLE, ST_WB} state_t;

    state_t                 state;
    logic [BEAT_BITS-1:0]   beat;
    logic [SET_BITS-1:0]    lat_set;
    logic                   lat_way;
    logic [31-PAGE_LSB:0]   lat_page;
    logic                   lat_keep;

    cmd_class_t             cls;
    logic [SET_BITS-1:0]    req_set, use_set;
    logic [WORD_BITS-1:0]   req_word;
    logic [1:0][31:0]       tag_rd;
    logic [1:0]             hit;
    logic                   use_way, effective, accept, need_wb, last_beat;
    logic [31:0]            tgt_tag, tag_wdata, word_rdata;
    logic                   tag_we, line_clr, word_we;

    assign req_set  = cmd_addr[PAGE_LSB-1:OFF_BITS];
    assign req_word = cmd_addr[OFF_BITS-1:2];
    assign cmd_busy = (state == ST_WB);

    cmu_decode i_decode (.op(cmd_op), .cls(cls));

    // Pick the set and way being worked on: latched during a writeback, else from the request.
    always_comb begin
        use_set   = cmd_busy ? lat_set : req_set;
        use_way   = cmd_busy ? lat_way : (cls.by_hit ? ~hit[0] : cmd_addr[0]);
        effective = cls.by_hit ? |hit : 1'b1;
    end

    cmu_tag_store #(.SET_BITS(SET_BITS), .PAGE_LSB(PAGE_LSB)) i_tags (
        .clk(clk), .rst_n(rst_n), .set_idx(use_set), .page(cmd_addr[31:PAGE_LSB]),
        .we(tag_we), .we_way(use_way), .wdata(tag_wdata), .tag_rd(tag_rd), .hit(hit)
    );

    assign tgt_tag   = tag_rd[use_way];
    assign accept    = cmd_start && !cmd_busy;
    assign need_wb   = accept && cls.wb && effective && tgt_tag[DIRTY_BIT] && tgt_tag[VALID_BIT];
    assign last_beat = cmd_busy && wb_ready && (beat == BEAT_BITS'(NUM_BEATS - 1));

    // Work out the tag write, the line clear and the word write for this cycle.
    always_comb begin
        tag_we    = 1'b0;
        tag_wdata = tgt_tag;
        line_clr  = 1'b0;
        word_we   = 1'b0;
        if (accept && !need_wb) begin
            if (cls.inval && effective) begin
                tag_we    = 1'b1;
                tag_wdata = tgt_tag & REPL_MASK;
                line_clr  = 1'b1;
            end
            if (cls.wr_tag) begin
                tag_we    = 1'b1;
                tag_wdata = xfer_in;
            end
            word_we = cls.wr_word;
        end
        if (last_beat) begin
            tag_we    = 1'b1;
            tag_wdata = lat_keep ? (tgt_tag & ~DIRTY_MASK) : (tgt_tag & REPL_MASK);
            line_clr  = !lat_keep;
        end
    end

    cmu_data_store #(.SET_BITS(SET_BITS), .WORD_BITS(WORD_BITS)) i_data (
        .clk(clk), .rst_n(rst_n), .set_idx(use_set), .way(use_way), .word_idx(req_word),
        .word_we(word_we), .word_wdata(xfer_in), .line_clr(line_clr), .beat(beat),
        .word_rdata(word_rdata), .quad_rdata(wb_data)
    );

    // Sequence the command: enter writeback when needed, count beats, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            beat            <= '0;
            lat_set         <= '0;
            lat_way         <= 1'b0;
            lat_page        <= '0;
            lat_keep        <= 1'b0;
            cmd_done        <= 1'b0;
            cmd_unsupported <= 1'b0;
            xfer_out        <= '0;
        end else begin
            cmd_done        <= (accept && !need_wb) || last_beat;
            cmd_unsupported <= accept && cls.unknown;
            if (need_wb) begin
                state    <= ST_WB;
                beat     <= '0;
                lat_set  <= req_set;
                lat_way  <= use_way;
                lat_page <= tgt_tag[31:PAGE_LSB];
                lat_keep <= cls.keep;
            end else if (last_beat) begin
                state <= ST_IDLE;
            end else if (cmd_busy && wb_ready) begin
                beat <= beat + 1'b1;
            end
            if (accept && cls.rd_tag)  xfer_out <= tgt_tag;
            if (accept && cls.rd_word) xfer_out <= word_rdata;
        end
    end

    assign wb_valid = cmd_busy;
    assign wb_addr  = {lat_page, lat_set, beat, 4'b0000};

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    assert_busy_end_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> cmd_done);
    assert_unsup_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_unsupported |-> cmd_done);
    assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
endmodule

// File: tb/test_cache_maint_unit.sv
module test_cache_maint_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_start = 1'b0;
    logic [4:0]   cmd_op = '0;
    logic [31:0]  cmd_addr = '0;
    logic [31:0]  xfer_in = '0;
    logic         cmd_busy, cmd_done, cmd_unsupported, wb_valid;
    logic         wb_ready = 1'b1;
    logic [31:0]  xfer_out, wb_addr;
    logic [127:0] wb_data;

    int errors = 0;
    int checks = 0;
    int nbeats = 0;
    int lat = 0;
    int rdy_mode = 0;
    logic last_unsup;
    logic [31:0]  cap_addr [8];
    logic [127:0] cap_data [8];
    bit finished = 0;

    always #10 clk = ~clk;

    cache_maint_unit i_cache_maint_unit (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .xfer_in(xfer_in), .cmd_busy(cmd_busy),
        .cmd_done(cmd_done), .cmd_unsupported(cmd_unsupported), .xfer_out(xfer_out),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // Memory side: set ready for the next edge, record beats that will be taken there.
    always @(negedge clk) begin
        if (rdy_mode == 0) wb_ready = 1'b1;
        else if (rdy_mode == 1) wb_ready = ~wb_ready;
        else wb_ready = 1'b0;
        if (wb_valid && wb_ready) begin
            if (nbeats < 8) begin
                cap_addr[nbeats] = wb_addr;
                cap_data[nbeats] = wb_data;
            end
            nbeats++;
        end
    end

    function automatic logic [31:0] tv(int s, int w);
        return {20'h00100 + 20'(s * 2 + w), (w != 0) ? 12'h0B2 : 12'h0A3};
    endfunction
    function automatic logic [31:0] wv(int s, int w, int i);
        return 32'hC000_0000 | (32'(s) << 16) | (32'(w) << 12) | 32'(i);
    endfunction
    function automatic logic [31:0] ia(int s, int w, int i);
        return (32'(s) << 6) | (32'(i) << 2) | 32'(w);
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(logic [4:0] op, logic [31:0] addr, logic [31:0] xin);
        nbeats = 0;
        @(negedge clk);
        cmd_op = op; cmd_addr = addr; xfer_in = xin; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        lat = 1;
        while (!cmd_done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        last_unsup = cmd_unsupported;
        if (!cmd_done) chk("R12 done never seen", 0, 1);
    endtask

    task automatic rd_tag(int s, int w, logic [31:0] exp, string req);
        run_cmd(5'h10, ia(s, w, 0), 32'h0);
        chk(req, xfer_out, exp);
    endtask
    task automatic rd_word(int s, int w, int i, logic [31:0] exp, string req);
        run_cmd(5'h11, ia(s, w, i), 32'h0);
        chk(req, xfer_out, exp);
    endtask

    task automatic chk_beats(logic [31:0] base, int s, int w, string req);
        chk({req, " beat count"}, 128'(nbeats), 128'd4);
        for (int k = 0; k < 4; k++) begin
            chk({req, " beat addr"}, 128'(cap_addr[k]), 128'(base + 32'(16 * k)));
            chk({req, " beat data"}, cap_data[k],
                {wv(s, w, 4*k+3), wv(s, w, 4*k+2), wv(s, w, 4*k+1), wv(s, w, 4*k)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in storage
        chk("R1 done", 128'(cmd_done), 0);
        chk("R1 wb_valid", 128'(wb_valid), 0);
        chk("R1 busy", 128'(cmd_busy), 0);
        chk("R1 unsupported", 128'(cmd_unsupported), 0);
        chk("R1 xfer_out", 128'(xfer_out), 0);
        rd_tag(63, 1, 32'h0, "R1 tag zero");
        rd_word(17, 0, 9, 32'h0, "R1 word zero");

        // R2: write all tags, then read all back; R12 latency of one cycle
        for (int s = 0; s < 64; s++)
            for (int w = 0; w < 2; w++)
                run_cmd(5'h12, ia(s, w, 0) | 32'hFFFF_F000, tv(s, w));
        chk("R12 non-writeback latency", 128'(lat), 128'd1);
        for (int s = 0; s < 64; s++)
            for (int w = 0; w < 2; w++)
                rd_tag(s, w, tv(s, w), "R2 tag sweep");

        // R3: data word sweep on two lines
        for (int i = 0; i < 16; i++) begin
            run_cmd(5'h13, ia(9, 1, i), wv(9, 1, i));
            run_cmd(5'h13, ia(40, 0, i), wv(40, 0, i));
        end
        for (int i = 0; i < 16; i++) begin
            rd_word(9, 1, i, wv(9, 1, i), "R3 word sweep");
            rd_word(40, 0, i, wv(40, 0, i), "R3 word sweep");
        end

        // R4/R5: hit invalidate hitting way 1 of set 9
        run_cmd(5'h1A, {20'h00113, 6'd9, 6'd0}, 32'h0);
        chk("R4 clean hit no beats", 128'(nbeats), 0);
        rd_tag(9, 1, 32'h10, "R5 keeps only replacement flag");
        rd_tag(9, 0, tv(9, 0), "R4 other way untouched");
        for (int i = 0; i < 16; i++) rd_word(9, 1, i, 32'h0, "R5 line zeroed");

        // R4: miss leaves everything
        run_cmd(5'h1A, {20'h00777, 6'd9, 6'd0}, 32'h0);
        rd_tag(9, 0, tv(9, 0), "R4 miss no effect");

        // R4/R7/R8: both ways match, way 0 dirty wins, keep variant
        run_cmd(5'h12, ia(40, 0, 0), 32'h005550E3);
        run_cmd(5'h12, ia(40, 1, 0), 32'h005550E3);
        run_cmd(5'h1C, {20'h00555, 6'd40, 6'd0}, 32'h0);
        chk_beats(32'h00555A00, 40, 0, "R7 keep writeback");
        chk("R12 writeback latency", 128'(lat), 128'd5);
        rd_tag(40, 0, 32'h005550A3, "R8 only dirty cleared");
        rd_tag(40, 1, 32'h005550E3, "R4 way0 priority");
        rd_word(40, 0, 7, wv(40, 0, 7), "R8 data kept");

        // R9/R5/R7: index writeback invalidate, page from stored tag, ready toggling
        for (int i = 0; i < 16; i++) run_cmd(5'h13, ia(40, 1, i), wv(40, 1, i));
        run_cmd(5'h12, ia(40, 1, 0), 32'h005550F3);
        rdy_mode = 1;
        run_cmd(5'h14, {20'h00ABC, 6'd40, 6'd1}, 32'h0);
        rdy_mode = 0;
        chk_beats(32'h00555A00, 40, 1, "R9 index writeback");
        rd_tag(40, 1, 32'h10, "R5 index wb invalidate tag");
        rd_word(40, 1, 15, 32'h0, "R5 index wb invalidate data");

        // R6: clean valid line, writeback-invalidate sends nothing
        run_cmd(5'h18, {20'h00112, 6'd9, 6'd0}, 32'h0);
        chk("R6 clean no beats", 128'(nbeats), 0);
        rd_tag(9, 0, 32'h0, "R6 clean still invalidated");

        // R4/R6: dirty but not valid: no hit, no beats
        run_cmd(5'h12, ia(12, 0, 0), 32'h00300040);
        run_cmd(5'h18, {20'h00300, 6'd12, 6'd0}, 32'h0);
        chk("R4 invalid no hit beats", 128'(nbeats), 0);
        rd_tag(12, 0, 32'h00300040, "R4 invalid tag untouched");
        run_cmd(5'h14, ia(12, 0, 0), 32'h0);
        chk("R6 not valid no beats", 128'(nbeats), 0);
        rd_tag(12, 0, 32'h0, "R6 index invalidate tag");

        // R5: index invalidate on a dirty line never writes back
        run_cmd(5'h12, ia(20, 1, 0), 32'h004440F3);
        run_cmd(5'h13, ia(20, 1, 3), 32'h00001234);
        run_cmd(5'h16, ia(20, 1, 0), 32'h0);
        chk("R5 index inval no beats", 128'(nbeats), 0);
        rd_tag(20, 1, 32'h10, "R5 index inval tag");
        rd_word(20, 1, 3, 32'h0, "R5 index inval data");

        // R12: start during a stalled writeback is ignored
        for (int i = 0; i < 16; i++) run_cmd(5'h13, ia(30, 0, i), wv(30, 0, i));
        run_cmd(5'h12, ia(30, 0, 0), 32'h006660E3);
        nbeats = 0;
        rdy_mode = 2;
        @(negedge clk);
        cmd_op = 5'h18; cmd_addr = {20'h00666, 6'd30, 6'd0}; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        chk("R12 busy during writeback", 128'(cmd_busy), 1);
        cmd_op = 5'h12; cmd_addr = ia(30, 1, 0); xfer_in = 32'hDEADBEEF; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        rdy_mode = 0;
        lat = 0;
        while (!cmd_done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk_beats(32'h00666A00 - 32'h00000A00 + 32'h00000780, 30, 0, "R7 stalled writeback");
        rd_tag(30, 1, tv(30, 1), "R12 start while busy ignored");
        rd_tag(30, 0, 32'h0, "R5 after stalled writeback");

        // R10: no-op codes
        rd_tag(30, 1, tv(30, 1), "R10 setup");
        run_cmd(5'h07, ia(30, 1, 0), 32'h0);
        chk("R10 latency", 128'(lat), 1);
        chk("R10 not unsupported", 128'(last_unsup), 0);
        chk("R10 xfer_out kept", 128'(xfer_out), 128'(tv(30, 1)));
        run_cmd(5'h0C, ia(30, 1, 0), 32'h0);
        chk("R10 latency", 128'(lat), 1);
        chk("R10 not unsupported", 128'(last_unsup), 0);
        rd_tag(30, 1, tv(30, 1), "R10 tag unchanged");

        // R11: every code outside the command set
        for (int op = 0; op < 32; op++) begin
            if (!(op inside {5'h07, 5'h0C, 5'h10, 5'h11, 5'h12, 5'h13, 5'h14,
                             5'h16, 5'h18, 5'h1A, 5'h1C})) begin
                run_cmd(5'(op), ia(30, 1, 0), 32'h12345678);
                chk("R11 latency", 128'(lat), 1);
                chk("R11 unsupported flag", 128'(last_unsup), 1);
                chk("R11 no beats", 128'(nbeats), 0);
                chk("R11 xfer_out kept", 128'(xfer_out), 128'(tv(30, 1)));
            end
        end
        rd_tag(30, 1, tv(30, 1), "R11 tag unchanged");
        rd_word(30, 1, 0, 32'h0, "R11 data unchanged");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule